// File: doc/BRIEF.md
# Sliding-Window Vector Multiply-Accumulate Array

This block is the multiply-accumulate datapath of a wide vector unit, sized for convolution kernels. Two 512-bit vector operands are held as 64 signed byte lanes. A 32-bit scalar word carries packed filter coefficients. A 1536-bit accumulator holds 64 lanes of 24 bits, or 32 lanes of 48 bits in the wide-operand modes. Each issued operation adds a set of signed products to every accumulator lane. The updated accumulator comes out one clock later, together with a valid flag.

The main mode computes four filter taps in one operation. The two vector operands are joined, with `vr_i` in the low half and `vs_i` in the high half, and read through a window that slides one byte per tap. Each lane therefore multiplies four neighbouring samples by four scalar coefficients. Paired modes produce two products per lane, in four forms:
- byte lanes times scalar bytes;
- byte lanes times byte lanes;
- 16-bit lanes times scalar bytes;
- 16-bit lanes times scalar halfwords.

All operands are two's complement. Every accumulator slice wraps on overflow.

Top module: `sw_quad_mac`

## Requirements
- R1: While `rst_ni` is low, and until the first accepted operation, `acc_o` is all zeros and `valid_o` is low.
- R2: An operation presented with `valid_i` high at a rising edge is captured there. Its result appears on `acc_o`, with `valid_o` high, from that edge until the next one. `valid_o` is low after any edge that sampled `valid_i` low.
- R3: After an edge that sampled `valid_i` low, `acc_o` keeps its previous value, whatever the other inputs do.
- R4: Window byte i of tap k (k = 0..3) is byte i+k of the 1024-bit concatenation {`vs_i`, `vr_i`}. Byte 0 is bits [7:0] of `vr_i`, and byte 64 is bits [7:0] of `vs_i`.
- R5: With `mode_i` = 0 (quad scalar), for each byte lane i: acc[i] += c0*w0[i] + c1*w1[i] + c2*w2[i] + c3*w3[i]. Here wk is tap k of R4, and ck is byte k of `scalar_i` (bits [8k+7:8k]). Accumulator lane i is bits [24i+23:24i].
- R6: With `mode_i` = 1 (paired scalar, bytes), acc[i] += c0*vr[i] + c1*vs[i], using coefficient bytes 0 and 1 of `scalar_i`.
- R7: With `mode_i` = 2 (paired vector, bytes), acc[i] += vr[i]*vs[i] + w1[i]*w2[i], using the window taps of R4.
- R8: With `mode_i` = 3 (paired, 16-bit lanes times bytes), there are 32 lanes. Lane j is halfword j of each vector (bits [16j+15:16j]) and owns accumulator bits [48j+47:48j]. The lane computes acc[j] += c0*vr[j] + c1*vs[j], where c0 and c1 are bytes 0 and 1 of `scalar_i`, sign-extended.
- R9: With `mode_i` = 4 (paired, 16-bit times 16-bit), lanes are as in R8. The lane computes acc[j] += h0*vr[j] + h1*vs[j], with h0 = `scalar_i`[15:0] and h1 = `scalar_i`[31:16].
- R10: All operands are signed two's complement. Sums wrap modulo 2^24 per byte lane, or 2^48 per 16-bit lane, with no carry into neighbouring lanes.
- R11: `mode_i` values 5 to 7 return `acc_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation issue strobe |
| mode_i | input | 3 | Operation select (R5 to R11) |
| vr_i | input | 512 | First vector operand, low half of the window |
| vs_i | input | 512 | Second vector operand, high half of the window |
| scalar_i | input | 32 | Packed coefficients |
| acc_i | input | 1536 | Accumulator in |
| acc_o | output | 1536 | Registered updated accumulator |
| valid_o | output | 1 | Result valid |

## Verification
Every result is due exactly one rising edge after the edge that samples `valid_i` high. The bench applies operands at a falling edge and drops `valid_i` at the next falling edge, just after the capturing rising edge. It compares `acc_o` and `valid_o` at that same falling edge. One more idle cycle follows, with all operands scrambled, after which `acc_o` must be unchanged and `valid_o` low. This separates the one-cycle latency from the hold behaviour.

// File: rtl/sw_mac_pkg.sv
package sw_mac_pkg;
  typedef enum logic [2:0] {
    MODE_QUAD_SV   = 3'd0,
    MODE_PAIR_SV8  = 3'd1,
    MODE_PAIR_VV8  = 3'd2,
    MODE_PAIR_SV16 = 3'd3,
    MODE_PAIR_HH16 = 3'd4
  } mac_mode_e;
endpackage

// File: rtl/sw_window.sv
module sw_window #(
  parameter int LANES = 64,
  parameter int BW    = 8,
  parameter int TAPS  = 4
) (
  input  logic [LANES*BW-1:0]             lo_i,
  input  logic [LANES*BW-1:0]             hi_i,
  output logic [TAPS-1:0][LANES*BW-1:0]   win_o
);
  localparam int VW = LANES * BW;
  logic [2*VW-1:0] cat;
  assign cat = {hi_i, lo_i};

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign win_o[k] = cat[k*BW +: VW];
  end
endmodule

// File: rtl/sw_mac_lane.sv
module sw_mac_lane #(
  parameter int BW   = 8,
  parameter int AW   = 24,
  parameter int TAPS = 4
) (
  input  logic [TAPS-1:0][BW-1:0] a_i,
  input  logic [TAPS-1:0][BW-1:0] b_i,
  input  logic [AW-1:0]           acc_i,
  output logic [AW-1:0]           acc_o
);
  localparam int PW = 2 * BW;
  logic signed [PW-1:0] prod [TAPS];
  logic signed [AW-1:0] sum;

  always_comb begin
    sum = $signed(acc_i);
    for (int k = 0; k < TAPS; k++) begin
      prod[k] = $signed(a_i[k]) * $signed(b_i[k]);
      sum     = sum + AW'(prod[k]);
    end
  end
  assign acc_o = sum;

  // R10: zero multiplicands leave the slice untouched
  always_comb begin
    if (a_i == '0) a_r10_zero_pass : assert (acc_o == acc_i);
  end
endmodule

// File: rtl/sw_quad_mac.sv
module sw_quad_mac
  import sw_mac_pkg::*;
#(
  parameter int LANES = 64,
  parameter int BW    = 8,
  parameter int AW    = 24,
  parameter int TAPS  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2:0]            mode_i,
  input  logic [LANES*BW-1:0]   vr_i,
  input  logic [LANES*BW-1:0]   vs_i,
  input  logic [TAPS*BW-1:0]    scalar_i,
  input  logic [LANES*AW-1:0]   acc_i,
  output logic [LANES*AW-1:0]   acc_o,
  output logic                  valid_o
);
  localparam int VW    = LANES * BW;
  localparam int ACCW  = LANES * AW;
  localparam int HL    = LANES / 2;
  localparam int HW    = 2 * BW;
  localparam int HAW   = 2 * AW;

  mac_mode_e mode;
  assign mode = mac_mode_e'(mode_i);

  logic [TAPS-1:0][VW-1:0] win;
  sw_window #(.LANES(LANES), .BW(BW), .TAPS(TAPS)) u_win (
    .lo_i (vr_i),
    .hi_i (vs_i),
    .win_o(win)
  );

  logic [ACCW-1:0] res8, res16, res;

  // byte lanes
  for (genvar i = 0; i < LANES; i++) begin : g_l8
    logic [TAPS-1:0][BW-1:0] a, b;
    always_comb begin
      a = '0;
      b = '0;
      unique case (mode)
        MODE_QUAD_SV: for (int k = 0; k < TAPS; k++) begin
          a[k] = win[k][i*BW +: BW];
          b[k] = scalar_i[k*BW +: BW];
        end
        MODE_PAIR_SV8: begin
          a[0] = vr_i[i*BW +: BW]; b[0] = scalar_i[0 +: BW];
          a[1] = vs_i[i*BW +: BW]; b[1] = scalar_i[BW +: BW];
        end
        MODE_PAIR_VV8: begin
          a[0] = vr_i[i*BW +: BW];   b[0] = vs_i[i*BW +: BW];
          a[1] = win[1][i*BW +: BW]; b[1] = win[2][i*BW +: BW];
        end
        default: ;
      endcase
    end
    sw_mac_lane #(.BW(BW), .AW(AW), .TAPS(TAPS)) u_lane (
      .a_i  (a),
      .b_i  (b),
      .acc_i(acc_i[i*AW +: AW]),
      .acc_o(res8[i*AW +: AW])
    );
  end

  // halfword lanes
  for (genvar j = 0; j < HL; j++) begin : g_l16
    logic [1:0][HW-1:0] a, b;
    always_comb begin
      a = '0;
      b = '0;
      unique case (mode)
        MODE_PAIR_SV16: begin
          a[0] = vr_i[j*HW +: HW]; b[0] = HW'($signed(scalar_i[0 +: BW]));
          a[1] = vs_i[j*HW +: HW]; b[1] = HW'($signed(scalar_i[BW +: BW]));
        end
        MODE_PAIR_HH16: begin
          a[0] = vr_i[j*HW +: HW]; b[0] = scalar_i[0 +: HW];
          a[1] = vs_i[j*HW +: HW]; b[1] = scalar_i[HW +: HW];
        end
        default: ;
      endcase
    end
    sw_mac_lane #(.BW(HW), .AW(HAW), .TAPS(2)) u_lane (
      .a_i  (a),
      .b_i  (b),
      .acc_i(acc_i[j*HAW +: HAW]),
      .acc_o(res16[j*HAW +: HAW])
    );
  end

  always_comb begin
    unique case (mode)
      MODE_QUAD_SV, MODE_PAIR_SV8, MODE_PAIR_VV8: res = res8;
      MODE_PAIR_SV16, MODE_PAIR_HH16:             res = res16;
      default:                                    res = acc_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) acc_o <= res;
    end
  end

  a_r2_valid_rise : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_drop : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r3_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_o));
  a_r11_unused_mode : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i > 3'd4) |=> acc_o == $past(acc_i));
endmodule

// File: tb/sw_quad_mac_test.sv
module sw_quad_mac_test;
  localparam int VW = 512;
  localparam int AWD = 1536;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           valid = 1'b0;
  logic [2:0]     mode = '0;
  logic [VW-1:0]  vr = '0, vs = '0;
  logic [31:0]    sc = '0;
  logic [AWD-1:0] acc_in = '0;
  logic [AWD-1:0] acc_out;
  logic           valid_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  sw_quad_mac uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode),
    .vr_i(vr), .vs_i(vs), .scalar_i(sc), .acc_i(acc_in),
    .acc_o(acc_out), .valid_o(valid_out)
  );

  function automatic logic [31:0] nxt(logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  task automatic rnd_vec(output logic [AWD-1:0] v);
    for (int w = 0; w < AWD/32; w++) begin
      rng = nxt(rng);
      v[w*32 +: 32] = rng;
    end
  endtask

  function automatic longint sx(logic [63:0] v, int bits);
    return longint'(v << (64 - bits)) >>> (64 - bits);
  endfunction

  function automatic logic [AWD-1:0] model(int m, logic [VW-1:0] a, logic [VW-1:0] b,
                                           logic [31:0] s, logic [AWD-1:0] acc);
    logic [2*VW-1:0] cat;
    logic [AWD-1:0] r;
    longint t;
    cat = {b, a};
    r = acc;
    if (m <= 2) begin
      for (int i = 0; i < 64; i++) begin
        t = sx(64'(acc[i*24 +: 24]), 24);
        if (m == 0)
          for (int k = 0; k < 4; k++)
            t += sx(64'(cat[(i+k)*8 +: 8]), 8) * sx(64'(s[k*8 +: 8]), 8);
        else if (m == 1)
          t += sx(64'(a[i*8 +: 8]), 8) * sx(64'(s[7:0]), 8)
             + sx(64'(b[i*8 +: 8]), 8) * sx(64'(s[15:8]), 8);
        else
          t += sx(64'(a[i*8 +: 8]), 8) * sx(64'(b[i*8 +: 8]), 8)
             + sx(64'(cat[(i+1)*8 +: 8]), 8) * sx(64'(cat[(i+2)*8 +: 8]), 8);
        r[i*24 +: 24] = t[23:0];
      end
    end else if (m <= 4) begin
      for (int j = 0; j < 32; j++) begin
        t = sx(64'(acc[j*48 +: 48]), 48);
        if (m == 3)
          t += sx(64'(a[j*16 +: 16]), 16) * sx(64'(s[7:0]), 8)
             + sx(64'(b[j*16 +: 16]), 16) * sx(64'(s[15:8]), 8);
        else
          t += sx(64'(a[j*16 +: 16]), 16) * sx(64'(s[15:0]), 16)
             + sx(64'(b[j*16 +: 16]), 16) * sx(64'(s[31:16]), 16);
        r[j*48 +: 48] = t[47:0];
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [AWD-1:0] act, logic [AWD-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // issue one op, check result (R2) and subsequent hold (R3)
  task automatic run_op(int m, logic [VW-1:0] a, logic [VW-1:0] b, logic [31:0] s,
                        logic [AWD-1:0] acc, string req);
    logic [AWD-1:0] exp, junk;
    exp = model(m, a, b, s, acc);
    @(negedge clk);
    mode = 3'(m); vr = a; vs = b; sc = s; acc_in = acc; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check(acc_out == exp, req, "result", acc_out, exp);
    check(valid_out == 1'b1, "R2", "valid_o high", AWD'(valid_out), AWD'(1));
    rnd_vec(junk);
    vr = junk[VW-1:0]; vs = junk[2*VW-1:VW]; acc_in = ~junk; sc = junk[31:0];
    @(negedge clk);
    check(acc_out == exp, "R3", "hold", acc_out, exp);
    check(valid_out == 1'b0, "R2", "valid_o low", AWD'(valid_out), AWD'(0));
  endtask

  initial begin
    logic [AWD-1:0] x, y, z;
    string tags [5] = '{"R5", "R6", "R7", "R8", "R9"};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(acc_out == '0 && valid_out == 1'b0, "R1", "reset", acc_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(acc_out == '0 && valid_out == 1'b0, "R1", "after release", acc_out, '0);

    // R4: window taps isolated via one-hot coefficient bytes in quad mode
    for (int k = 0; k < 4; k++) begin
      rnd_vec(x); rnd_vec(y);
      run_op(0, x[VW-1:0], y[VW-1:0], 32'(1) << (8*k), '0, "R4");
    end

    // main sweep over every mode with scrambled operands (R5..R9)
    for (int m = 0; m < 5; m++)
      for (int n = 0; n < 10; n++) begin
        rnd_vec(x); rnd_vec(y); rnd_vec(z);
        run_op(m, x[VW-1:0], y[VW-1:0], z[31:0], z, tags[m]);
      end

    // R10: wrap corners
    x = '0;
    for (int i = 0; i < 64; i++) x[i*24 +: 24] = 24'h7F_FFFF;
    run_op(0, {64{8'h80}}, {64{8'h80}}, 32'h8080_8080, x, "R10");
    run_op(2, {64{8'h80}}, {64{8'h80}}, 32'h0, x, "R10");
    x = '0;
    for (int j = 0; j < 32; j++) x[j*48 +: 48] = 48'h7FFF_FFFF_FFFF;
    run_op(4, {32{16'h8000}}, {32{16'h8000}}, 32'h8000_8000, x, "R10");
    run_op(3, {32{16'h7FFF}}, {32{16'h8000}}, 32'h0000_807F, ~x, "R10");

    // R11: unused codes pass accumulator through
    for (int m = 5; m < 8; m++) begin
      rnd_vec(x); rnd_vec(y); rnd_vec(z);
      run_op(m, x[VW-1:0], y[VW-1:0], z[31:0], z, "R11");
    end

    // back-to-back ops (R2)
    rnd_vec(x); rnd_vec(y); rnd_vec(z);
    @(negedge clk);
    mode = 3'd1; vr = x[VW-1:0]; vs = y[VW-1:0]; sc = z[31:0]; acc_in = z; valid = 1'b1;
    @(negedge clk);
    check(acc_out == model(1, x[VW-1:0], y[VW-1:0], z[31:0], z), "R2", "b2b first",
          acc_out, model(1, x[VW-1:0], y[VW-1:0], z[31:0], z));
    mode = 3'd0; acc_in = x;
    @(negedge clk);
    valid = 1'b0;
    check(acc_out == model(0, x[VW-1:0], y[VW-1:0], z[31:0], x), "R2", "b2b second",
          acc_out, model(0, x[VW-1:0], y[VW-1:0], z[31:0], x));

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule